// File: doc/BRIEF.md
# Reset Controller with Cause Flags

This block sequences the internal reset of a small microcontroller. It has four reset sources: a power-on condition, an active-low external reset pin, a brown-out detector output and a watchdog time-out strobe. It combines them into a single core reset. That reset stays asserted for a fixed number of clock cycles after the last active source goes away.

The power-on input acts asynchronously and sets the block to its reset state at once. The external pin and the brown-out input first pass through a flop synchroniser. The watchdog strobe is reduced to a pulse exactly one clock long. The hold count starts on the cycle after that pulse ends. Any reset event that arrives during the hold starts the count again.

Software reads a cause register to find out why the core was reset. It clears flags by writing zeros to them. Each flag has its own clearing rule. A power-on event clears the watchdog, brown-out and external flags and sets the power-on flag. The power-on flag can only be cleared by software.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `porActive` is high, `coreRst` is 1 at once, without waiting for a clock edge. The cause flags read 0x01 during this time.
- R2: `coreRst` falls on exactly the `HOLD_CYCLES`-th rising clock edge after the last edge at which a reset source was active. It changes only at clock edges.
- R3: A low level on `extRstN` is seen after `SYNC_STAGES` flop stages. At the next edge after that, it sets bit 1 (external flag) and asserts `coreRst`.
- R4: A high level on `brownOut` is seen after `SYNC_STAGES` flop stages. At the next edge after that, it sets bit 2 (brown-out flag). It keeps `coreRst` asserted for as long as the level stays high.
- R5: A rising edge on `wdtTimeout` makes an internal pulse exactly one cycle long, however long the input stays high. At the edge where the pulse is seen, bit 3 (watchdog flag) is set and `coreRst` is asserted. The hold count starts after the pulse falls.
- R6: A reset event during the hold period restarts the hold count from zero.
- R7: A write with `regWrEn` clears every flag bit written as 0 and leaves every flag bit written as 1 unchanged.
- R8: If a flag's set event and a software clear of that flag fall on the same edge, the flag ends up set.
- R9: A power-on event clears bits 3..1 and sets bit 0. Watchdog, brown-out and external events never clear bit 0.
- R10: Bits 7..4 of the register always read 0. Writes to those bits have no effect.
- R11: `regRdata` is combinational. It equals {4'b0, flags} while `regRdEn` is 1 and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| porActive | input | 1 | Power-on condition, active high, asynchronous |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| brownOut | input | 1 | Brown-out detector output with hysteresis, active high, asynchronous |
| wdtTimeout | input | 1 | Watchdog time-out strobe, synchronous to `clk` |
| regRdEn | input | 1 | Decoded read enable for the cause register |
| regWrEn | input | 1 | Decoded write enable for the cause register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data |
| coreRst | output | 1 | Internal reset, active high |

## Verification
The bench builds the block with `HOLD_CYCLES` = 5 and `SYNC_STAGES` = 2. With these values every release edge of the hold window falls within a few cycles of its source. This makes it practical to land an external event in the middle of a watchdog hold and watch the count restart. A brown-out level held across a clearing write shows the set-over-clear priority. A second power-on pulse, raised between clock edges after all flags are set, covers the asynchronous flag reset.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int FLAG_W = 4;
  localparam int REG_W  = 8;

  // Bit positions software decodes in the cause register.
  localparam int BIT_POR = 0;
  localparam int BIT_EXT = 1;
  localparam int BIT_BOR = 2;
  localparam int BIT_WDT = 3;

  localparam logic [FLAG_W-1:0] FLAGS_AT_POR = FLAG_W'(1) << BIT_POR;

  // Strobes from the sequencer to the flag datapath, one per clocked source.
  typedef struct packed {
    logic setWdt;
    logic setBor;
    logic setExt;
  } rstStrobe_t;

endpackage

// File: rtl/rst_cause_seq.sv
module rst_cause_seq
  import rst_cause_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porActive,
  input  logic       extRstN,
  input  logic       brownOut,
  input  logic       wdtTimeout,
  output rstStrobe_t strobe,
  output logic       coreRst
);

  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_CYCLES - 1);

  // Index 1 carries brown-out, index 0 carries the external request.
  logic [1:0] rawReq;
  logic [1:0] syncPipe [SYNC_STAGES];
  logic       wdtPrev;
  logic       wdtPulse;
  logic       srcActive;
  logic [CNT_W-1:0] holdCnt;
  logic       rstQ;

  assign rawReq = {brownOut, ~extRstN};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or posedge porActive) begin
        if (porActive) syncPipe[s] <= '0;
        else           syncPipe[s] <= rawReq;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge porActive) begin
        if (porActive) syncPipe[s] <= '0;
        else           syncPipe[s] <= syncPipe[s-1];
      end
    end
  end

  // The watchdog strobe is cut to one cycle on its rising edge.
  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) begin
      wdtPrev  <= 1'b0;
      wdtPulse <= 1'b0;
    end else begin
      wdtPrev  <= wdtTimeout;
      wdtPulse <= wdtTimeout & ~wdtPrev;
    end
  end

  assign strobe.setExt = syncPipe[SYNC_STAGES-1][0];
  assign strobe.setBor = syncPipe[SYNC_STAGES-1][1];
  assign strobe.setWdt = wdtPulse;
  assign srcActive     = strobe.setExt | strobe.setBor | strobe.setWdt;

  // Asserted at once by power-on, released only at a clock edge.
  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) begin
      holdCnt <= '0;
      rstQ    <= 1'b1;
    end else if (srcActive) begin
      holdCnt <= '0;
      rstQ    <= 1'b1;
    end else if (holdCnt == LAST_CNT) begin
      rstQ    <= 1'b0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
      rstQ    <= 1'b1;
    end
  end

  assign coreRst = rstQ;

endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              porActive,
  input  rstStrobe_t        strobe,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [FLAG_W-1:0] wrBits,
  output logic [REG_W-1:0]  regRdata,
  output logic [FLAG_W-1:0] flagQ
);

  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] keepVec;

  always_comb begin
    setVec          = '0;
    setVec[BIT_WDT] = strobe.setWdt;
    setVec[BIT_BOR] = strobe.setBor;
    setVec[BIT_EXT] = strobe.setExt;
  end

  // A zero written clears its flag; a one keeps it.
  assign keepVec = regWrEn ? (flagQ & wrBits) : flagQ;

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) flagQ <= FLAGS_AT_POR;
    else           flagQ <= keepVec | setVec;
  end

  assign regRdata = regRdEn ? REG_W'(flagQ) : '0;

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porActive,
  input  logic       extRstN,
  input  logic       brownOut,
  input  logic       wdtTimeout,
  input  logic       regRdEn,
  input  logic       regWrEn,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       coreRst
);

  rstStrobe_t        strobe;
  logic [FLAG_W-1:0] flagQ;

  rst_cause_seq #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_seq (
    .clk       (clk),
    .porActive (porActive),
    .extRstN   (extRstN),
    .brownOut  (brownOut),
    .wdtTimeout(wdtTimeout),
    .strobe    (strobe),
    .coreRst   (coreRst)
  );

  rst_cause_flags u_flags (
    .clk      (clk),
    .porActive(porActive),
    .strobe   (strobe),
    .regRdEn  (regRdEn),
    .regWrEn  (regWrEn),
    .wrBits   (regWdata[FLAG_W-1:0]),
    .regRdata (regRdata),
    .flagQ    (flagQ)
  );

endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk #(
  parameter int HOLD_CYCLES = 16
) (
  input logic       clk,
  input logic       porActive,
  input logic       coreRst,
  input logic       regRdEn,
  input logic       regWrEn,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic [3:0] flagQ,
  input logic       setWdt,
  input logic       setBor,
  input logic       setExt
);

  logic anySet;
  int   quiet;

  assign anySet = setWdt | setBor | setExt;

  // Edges since the last active source, saturating at the hold length.
  always_ff @(posedge clk or posedge porActive) begin
    if (porActive)                 quiet <= 0;
    else if (anySet)               quiet <= 0;
    else if (quiet != HOLD_CYCLES) quiet <= quiet + 1;
  end

  always @(negedge clk) begin
    if (porActive === 1'b1) begin
      assert_por_state_R1: assert (coreRst === 1'b1 && flagQ === 4'b0001)
        else $error("R1 power-on state wrong");
    end
  end

  assert_hold_window_R2: assert property (@(posedge clk) disable iff (porActive)
    coreRst == (quiet != HOLD_CYCLES));

  // Covers R3, R4 and R5: a clocked source asserts reset at the next edge.
  assert_src_asserts_rst_R3: assert property (@(posedge clk) disable iff (porActive)
    anySet |=> coreRst);

  assert_wdt_single_pulse_R5: assert property (@(posedge clk) disable iff (porActive)
    setWdt |=> !setWdt);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (porActive)
    (setExt && regWrEn) |=> flagQ[1]);

  assert_por_flag_kept_R9: assert property (@(posedge clk) disable iff (porActive)
    (flagQ[0] && !regWrEn) |=> flagQ[0]);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (porActive)
    (regWrEn && (regWdata[7:4] != 4'h0)) |=> (regRdata[7:4] == 4'h0));

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (porActive)
    !regRdEn |-> (regRdata == 8'h00));

endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk      (clk),
  .porActive(porActive),
  .coreRst  (coreRst),
  .regRdEn  (regRdEn),
  .regWrEn  (regWrEn),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .flagQ    (flagQ),
  .setWdt   (strobe.setWdt),
  .setBor   (strobe.setBor),
  .setExt   (strobe.setExt)
);

// File: tb/rst_cause_ctrl_bench.sv
module rst_cause_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 5;
  localparam int SYNC       = 2;

  logic       clk = 1'b0;
  logic       porActive;
  logic       extRstN;
  logic       brownOut;
  logic       wdtTimeout;
  logic       regRdEn;
  logic       regWrEn;
  logic [7:0] regWdata;
  logic [7:0] regRdata;
  logic       coreRst;

  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  string curReq = "R1";

  rst_cause_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) u_rst_cause_ctrl (
    .clk(clk), .porActive(porActive), .extRstN(extRstN), .brownOut(brownOut),
    .wdtTimeout(wdtTimeout), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .coreRst(coreRst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model, advanced at each rising edge.
  bit       mExt [SYNC];
  bit       mBor [SYNC];
  bit       mWdtPrev, mPulse, mRst = 1'b1, mSrc;
  int       mCnt;
  bit [3:0] mFlag = 4'b0001;
  bit [3:0] mSet;

  always @(posedge clk) begin
    if (porActive) begin
      for (int s = 0; s < SYNC; s++) begin mExt[s] = 0; mBor[s] = 0; end
      mWdtPrev = 0; mPulse = 0; mCnt = 0; mRst = 1; mFlag = 4'b0001;
    end else begin
      mSrc = mExt[SYNC-1] | mBor[SYNC-1] | mPulse;
      mSet = {mPulse, mBor[SYNC-1], mExt[SYNC-1], 1'b0};
      if (regWrEn) mFlag = mFlag & regWdata[3:0];
      mFlag = mFlag | mSet;
      if (mSrc) begin mCnt = 0; mRst = 1; end
      else if (mCnt >= HOLD - 1) mRst = 0;
      else begin mCnt++; mRst = 1; end
      for (int s = SYNC - 1; s > 0; s--) begin mExt[s] = mExt[s-1]; mBor[s] = mBor[s-1]; end
      mExt[0] = !extRstN;
      mBor[0] = brownOut;
      mPulse = wdtTimeout && !mWdtPrev;
      mWdtPrev = wdtTimeout;
    end
  end

  always @(negedge clk) begin
    bit       expRst;
    bit [3:0] expFlag;
    bit [7:0] expRd;
    expRst  = porActive ? 1'b1 : mRst;
    expFlag = porActive ? 4'b0001 : mFlag;
    expRd   = regRdEn ? {4'b0000, expFlag} : 8'h00;
    compared++;
    if (coreRst !== expRst) begin
      mismatched++;
      $display("FAIL %s coreRst actual=%0b expected=%0b t=%0t", curReq, coreRst, expRst, $time);
    end
    compared++;
    if (regRdata !== expRd) begin
      mismatched++;
      $display("FAIL %s regRdata actual=%02h expected=%02h t=%0t", curReq, regRdata, expRd, $time);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic writeReg(input logic [7:0] d);
    regWrEn = 1'b1; regWdata = d;
    tick(1);
    regWrEn = 1'b0; regWdata = 8'h00;
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL %s watchdog actual=running expected=finished", curReq);
      finishRun();
    end
  end

  initial begin
    porActive = 1'b1; extRstN = 1'b1; brownOut = 1'b0; wdtTimeout = 1'b0;
    regRdEn = 1'b1; regWrEn = 1'b0; regWdata = 8'h00;
    curReq = "R1"; tick(4);
    porActive = 1'b0;
    curReq = "R2"; tick(HOLD + 3);

    curReq = "R10"; writeReg(8'hF1); tick(2);
    curReq = "R7";  writeReg(8'hFE); tick(2);

    curReq = "R3"; extRstN = 1'b0; tick(3);
    extRstN = 1'b1; tick(HOLD + 5);

    curReq = "R4"; brownOut = 1'b1; tick(7);
    brownOut = 1'b0; tick(HOLD + 5);

    curReq = "R5"; wdtTimeout = 1'b1; tick(4);
    wdtTimeout = 1'b0; tick(HOLD + 4);

    curReq = "R7"; writeReg(8'hFF); tick(1);
    writeReg(8'hF9); tick(2);

    curReq = "R6"; wdtTimeout = 1'b1; tick(1);
    wdtTimeout = 1'b0; tick(3);
    extRstN = 1'b0; tick(1);
    extRstN = 1'b1; tick(HOLD + 6);

    curReq = "R8"; brownOut = 1'b1; tick(4);
    writeReg(8'h00); tick(1);
    brownOut = 1'b0; tick(HOLD + 4);

    curReq = "R11"; regRdEn = 1'b0; tick(3);
    regRdEn = 1'b1; tick(1);

    curReq = "R9"; wdtTimeout = 1'b1; tick(1);
    wdtTimeout = 1'b0; extRstN = 1'b0; tick(4);
    extRstN = 1'b1; tick(HOLD + 4);
    #1 porActive = 1'b1; tick(3);
    porActive = 1'b0; tick(HOLD + 3);

    curReq = "R10"; writeReg(8'hF0); tick(3);
    finishRun();
  end

endmodule